// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judging only by its 48-bit destination address. It keeps a table of sixteen exact-match addresses. The table is filled from a setup frame that arrives as a byte stream, and each entry sits inside a fixed-size slot of that frame, with padding bytes between the useful ones.

For every received frame the block collects the first six bytes, which form the destination, and compares them at once against all sixteen entries and against the broadcast address. It then applies the inverse, promiscuous, receive-all and pass-multicast modes. It produces one verdict pulse that carries accept or reject and two status flags. The flags mark a frame that was taken only because of a permissive mode (filtering fail) or only because it was multicast. The frame length is checked first, and frames outside the legal range are refused whatever the address.

Top module: `rx_dest_filter`

## Requirements
- R1: `rx_len` is captured at `rx_start`. If it is below 14 or above 2048, the verdict is reject with both flags 0, whatever the address and the modes.
- R2: Setup-frame entry n occupies bytes 12n to 12n+11. The bytes at relative positions 0, 1, 4, 5, 8 and 9 become address bytes 0 to 5 of that entry, where byte 0 is compared with the first destination byte received. The bytes at relative positions 2, 3, 6, 7, 10 and 11 are ignored.
- R3: The table holds 16 entries and is all-zero after reset. A destination equal to any entry is accepted with both flags 0 when `mode_inverse` is 0.
- R4: The destination FF:FF:FF:FF:FF:FF is accepted in every mode, with both flags 0.
- R5: With `mode_promisc` or `mode_rx_all` set, a destination that matches no entry and is not broadcast is accepted with `flag_filter_fail`=1 and `flag_multicast`=0.
- R6: With `mode_pass_mcast` set, a destination whose first byte has bit 0 set is accepted with `flag_multicast`=1. This applies only if no match, broadcast, promiscuous or receive-all rule accepted it first, so at most one flag is ever set.
- R7: With `mode_inverse` set, the table-match result is inverted before the broadcast and mode rules are applied. A matching destination is then rejected unless another rule takes it, and a non-matching one is accepted with both flags 0.
- R8: `setup_done` pulses for one cycle in the cycle after the 192nd setup byte, and only if `setup_irq_en` was 1 at `setup_start`. Setup bytes after the 192nd are ignored until the next `setup_start`.
- R9: `verdict_valid` is a one-cycle pulse in the cycle after the sixth destination byte following `rx_start`. Bytes after the sixth, and bytes received with no preceding `rx_start`, produce no verdict.
- R10: After reset, and whenever `verdict_valid` is 0, `verdict_accept`, `flag_filter_fail`, `flag_multicast` and `setup_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_start | input | 1 | Begins a setup frame load |
| setup_valid | input | 1 | Setup byte strobe |
| setup_byte | input | 8 | Setup frame data byte |
| setup_irq_en | input | 1 | Request a completion pulse for this load, sampled at setup_start |
| rx_start | input | 1 | Begins a received frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received frame data byte |
| rx_len | input | 12 | Frame length in bytes, sampled at rx_start |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_pass_mcast | input | 1 | Pass every multicast frame |
| mode_inverse | input | 1 | Invert the table-match result |
| verdict_valid | output | 1 | Verdict pulse |
| verdict_accept | output | 1 | Frame accepted |
| flag_filter_fail | output | 1 | Accepted only through promiscuous or receive-all mode |
| flag_multicast | output | 1 | Accepted only through pass-multicast mode |
| setup_done | output | 1 | Setup frame completely loaded |

## Verification
The bench loads a table whose padding bytes differ from every address byte, then checks every one of the sixteen entries. A loader that picked the wrong offsets or the wrong entry stride would therefore reject a correct destination. Length bounds are probed on both sides of 14 and 2048, so a design that is off by one at either bound would accept a frame it should refuse, or refuse one it should accept.

Rule precedence is tested with destinations that satisfy two rules at once: a broadcast or a table hit while a permissive mode is on, and a multicast while promiscuous mode is on. A design with the wrong order would set a flag that should stay clear. The bench also checks that inverse mode turns hits into rejects, that a second setup load without the interrupt request stays silent and replaces the table, and that trailing or unframed bytes never produce a verdict pulse.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;

    localparam int MAC_BYTES     = 6;
    localparam int DEF_ENTRIES   = 16;
    localparam int DEF_STRIDE    = 12;
    localparam int DEF_MIN_LEN   = 14;
    localparam int DEF_MAX_LEN   = 2048;
    localparam int DEF_LEN_W     = 12;

    typedef logic [7:0] octet_t;
    // element 0 is the first byte on the wire
    typedef octet_t [MAC_BYTES-1:0] mac_t;

    typedef struct packed {
        logic promisc;
        logic rx_all;
        logic pass_mc;
        logic invert;
    } mode_t;

    typedef struct packed {
        logic accept;
        logic filt_fail;
        logic mcast;
    } verdict_t;

    // within a 12-byte slot only positions with bit 1 clear carry address data
    function automatic logic slot_pos_used(input logic [3:0] rel);
        return !rel[1];
    endfunction

    // positions 0,1,4,5,8,9 map to address bytes 0..5
    function automatic logic [2:0] slot_pos_byte(input logic [3:0] rel);
        return {rel[3:2], rel[0]};
    endfunction

endpackage

// File: rtl/rxf_addr_table.sv
module rxf_addr_table
    import rx_dest_filter_pkg::*;
#(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int STRIDE    = DEF_STRIDE
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_start,
    input  logic   ld_valid,
    input  octet_t ld_byte,
    input  logic   ld_irq_en,
    input  mac_t   cmp_addr,
    output logic   hit_any,
    output logic   ld_done
);
    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam int REL_W = $clog2(STRIDE);

    mac_t             tbl [N_ENTRIES];
    logic [IDX_W-1:0] idx;
    logic [REL_W-1:0] rel;
    logic             active;
    logic             irq_q;
    logic [N_ENTRIES-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) tbl[i] <= '0;
            idx     <= '0;
            rel     <= '0;
            active  <= 1'b0;
            irq_q   <= 1'b0;
            ld_done <= 1'b0;
        end else begin
            ld_done <= 1'b0;
            if (ld_start) begin
                idx    <= '0;
                rel    <= '0;
                active <= 1'b1;
                irq_q  <= ld_irq_en;
            end else if (ld_valid && active) begin
                if (slot_pos_used(4'(rel)))
                    tbl[idx][slot_pos_byte(4'(rel))] <= ld_byte;
                if (rel == REL_W'(STRIDE-1)) begin
                    rel <= '0;
                    if (idx == IDX_W'(N_ENTRIES-1)) begin
                        active  <= 1'b0;
                        ld_done <= irq_q;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    rel <= rel + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit[g] = (tbl[g] == cmp_addr);
    end

    assign hit_any = |hit;

    // completion pulse only when requested at load start
    p_done_needs_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> irq_q);
    // completion only after the final slot position has been consumed
    p_done_ends_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> !active && $past(ld_valid));

endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture
    import rx_dest_filter_pkg::*;
#(
    parameter int LEN_W   = DEF_LEN_W,
    parameter int MIN_LEN = DEF_MIN_LEN,
    parameter int MAX_LEN = DEF_MAX_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  octet_t           rx_byte,
    input  logic [LEN_W-1:0] rx_len,
    output mac_t             dest,
    output logic             complete,
    output logic             len_ok
);
    localparam logic [2:0] IDLE_CNT = 3'(MAC_BYTES);

    mac_t             part_q;
    logic [2:0]       cnt;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= IDLE_CNT;
            part_q <= '0;
            len_q  <= '0;
        end else if (rx_start) begin
            cnt   <= '0;
            len_q <= rx_len;
        end else if (rx_valid && cnt != IDLE_CNT) begin
            part_q[cnt] <= rx_byte;
            cnt         <= cnt + 3'd1;
        end
    end

    always_comb begin
        dest    = part_q;
        dest[MAC_BYTES-1] = rx_byte;
    end

    assign complete = rx_valid && !rx_start && (cnt == IDLE_CNT - 3'd1);
    assign len_ok   = (len_q >= LEN_W'(MIN_LEN)) && (len_q <= LEN_W'(MAX_LEN));

    // byte counter never leaves its idle value without a start
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= IDLE_CNT);
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == IDLE_CNT && !rx_start) |=> cnt == IDLE_CNT);

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rx_dest_filter_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     complete,
    input  mac_t     dest,
    input  logic     hit_any,
    input  mode_t    mode,
    input  logic     len_ok,
    output logic     out_valid,
    output verdict_t out_v
);
    verdict_t nxt;
    logic     bcast, mc_bit, pm, permissive;

    always_comb begin
        bcast       = &dest;
        mc_bit      = dest[0][0];
        pm          = hit_any ^ mode.invert;
        permissive  = mode.promisc | mode.rx_all;
        nxt.accept    = len_ok & (pm | bcast | permissive | (mode.pass_mc & mc_bit));
        nxt.filt_fail = len_ok & !pm & !bcast & permissive;
        nxt.mcast     = len_ok & !pm & !bcast & !permissive & mode.pass_mc & mc_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_v     <= '0;
        end else begin
            out_valid <= complete;
            out_v     <= complete ? nxt : '0;
        end
    end

    p_len_reject_r1: assert property (@(posedge clk) disable iff (rst)
        (complete && !len_ok) |=> out_valid && !out_v.accept);
    p_bcast_r4: assert property (@(posedge clk) disable iff (rst)
        (complete && len_ok && (&dest)) |=> out_v.accept && !out_v.filt_fail && !out_v.mcast);
    p_ff_mode_r5: assert property (@(posedge clk) disable iff (rst)
        out_v.filt_fail |-> $past(mode.promisc || mode.rx_all));
    p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
        !(out_v.filt_fail && out_v.mcast));
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_v == '0);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rx_dest_filter_pkg::*;
#(
    parameter int N_ENTRIES = DEF_ENTRIES,
    parameter int STRIDE    = DEF_STRIDE,
    parameter int LEN_W     = DEF_LEN_W,
    parameter int MIN_LEN   = DEF_MIN_LEN,
    parameter int MAX_LEN   = DEF_MAX_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             setup_start,
    input  logic             setup_valid,
    input  logic [7:0]       setup_byte,
    input  logic             setup_irq_en,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             mode_promisc,
    input  logic             mode_rx_all,
    input  logic             mode_pass_mcast,
    input  logic             mode_inverse,
    output logic             verdict_valid,
    output logic             verdict_accept,
    output logic             flag_filter_fail,
    output logic             flag_multicast,
    output logic             setup_done
);
    mac_t     dest;
    logic     complete, len_ok, hit_any;
    mode_t    mode;
    verdict_t v;

    assign mode = '{promisc: mode_promisc, rx_all: mode_rx_all,
                    pass_mc: mode_pass_mcast, invert: mode_inverse};

    rxf_dest_capture #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cap (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_len(rx_len), .dest(dest),
        .complete(complete), .len_ok(len_ok)
    );

    rxf_addr_table #(.N_ENTRIES(N_ENTRIES), .STRIDE(STRIDE)) u_tbl (
        .clk(clk), .rst(rst), .ld_start(setup_start), .ld_valid(setup_valid),
        .ld_byte(setup_byte), .ld_irq_en(setup_irq_en), .cmp_addr(dest),
        .hit_any(hit_any), .ld_done(setup_done)
    );

    rxf_verdict u_dec (
        .clk(clk), .rst(rst), .complete(complete), .dest(dest),
        .hit_any(hit_any), .mode(mode), .len_ok(len_ok),
        .out_valid(verdict_valid), .out_v(v)
    );

    assign verdict_accept   = v.accept;
    assign flag_filter_fail = v.filt_fail;
    assign flag_multicast   = v.mcast;

    // a verdict always follows a data byte that was not a start cycle
    p_valid_after_byte_r9: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(rx_valid) && !$past(rx_start));
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

endmodule

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic setup_start = 0, setup_valid = 0, setup_irq_en = 0;
    logic [7:0] setup_byte = 0;
    logic rx_start = 0, rx_valid = 0;
    logic [7:0] rx_byte = 0;
    logic [11:0] rx_len = 0;
    logic m_pr = 0, m_ra = 0, m_mc = 0, m_inv = 0;
    logic verdict_valid, verdict_accept, flag_filter_fail, flag_multicast, setup_done;

    int checks = 0;
    int failures = 0;
    logic [7:0] tbl [16][6];

    always #2.5 clk = ~clk;

    rx_dest_filter dut (
        .clk(clk), .rst(rst), .setup_start(setup_start), .setup_valid(setup_valid),
        .setup_byte(setup_byte), .setup_irq_en(setup_irq_en), .rx_start(rx_start),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_len(rx_len),
        .mode_promisc(m_pr), .mode_rx_all(m_ra), .mode_pass_mcast(m_mc),
        .mode_inverse(m_inv), .verdict_valid(verdict_valid),
        .verdict_accept(verdict_accept), .flag_filter_fail(flag_filter_fail),
        .flag_multicast(flag_multicast), .setup_done(setup_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] abyte(input logic [47:0] a, input int k);
        return a[8*(5-k) +: 8];
    endfunction

    // expected {valid, accept, filter_fail, multicast}
    function automatic logic [3:0] model(input logic [47:0] a, input int len);
        logic hit = 1'b0;
        logic pm, bc, perm, mcb;
        for (int n = 0; n < 16; n++) begin
            logic same = 1'b1;
            for (int k = 0; k < 6; k++) if (tbl[n][k] != abyte(a, k)) same = 1'b0;
            if (same) hit = 1'b1;
        end
        if (len < 14 || len > 2048) return 4'b1000;
        pm = hit ^ m_inv;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        perm = m_pr | m_ra;
        mcb = abyte(a, 0) & 8'h01 ? 1'b1 : 1'b0;
        if (pm || bc) return 4'b1100;
        if (perm) return 4'b1110;
        if (m_mc && mcb) return 4'b1101;
        return 4'b1000;
    endfunction

    task automatic send_frame(input string tag, input logic [47:0] a, input int len);
        logic early = 1'b0;
        logic [3:0] got;
        @(negedge clk);
        rx_start = 1'b1; rx_len = 12'(len);
        @(negedge clk);
        rx_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            rx_valid = 1'b1; rx_byte = abyte(a, k);
            @(negedge clk);
            if (k < 5 && verdict_valid) early = 1'b1;
        end
        got = {verdict_valid, verdict_accept, flag_filter_fail, flag_multicast};
        chk({tag, " verdict"}, 32'(got), 32'(model(a, len)));
        chk("R9 no early verdict", 32'(early), 32'd0);
        rx_byte = 8'h00;            // trailing byte must be ignored
        @(negedge clk);
        chk("R9 trailing byte no verdict", 32'(verdict_valid), 32'd0);
        chk("R10 quiet outputs", 32'({verdict_accept, flag_filter_fail, flag_multicast}), 32'd0);
        rx_valid = 1'b0;
    endtask

    task automatic load_setup(input logic irq, input logic [7:0] base);
        logic early = 1'b0;
        for (int n = 0; n < 16; n++)
            for (int k = 0; k < 6; k++)
                tbl[n][k] = 8'(base + 8'(n*16) + 8'(k*2));
        @(negedge clk);
        setup_start = 1'b1; setup_irq_en = irq;
        @(negedge clk);
        setup_start = 1'b0; setup_irq_en = 1'b0;
        for (int i = 0; i < 192; i++) begin
            int n = i / 12;
            int r = i % 12;
            setup_valid = 1'b1;
            if (r[1] == 1'b0) setup_byte = tbl[n][(r >> 2) * 2 + (r & 1)];
            else setup_byte = 8'hC3;
            @(negedge clk);
            if (i < 191 && setup_done) early = 1'b1;
        end
        chk("R8 setup_done on completion", 32'(setup_done), 32'(irq));
        chk("R8 no early setup_done", 32'(early), 32'd0);
        for (int i = 0; i < 12; i++) begin   // surplus bytes, must not land in the table
            setup_byte = 8'h77;
            @(negedge clk);
            if (setup_done) early = 1'b1;
        end
        setup_valid = 1'b0;
        chk("R8 surplus bytes silent", 32'(early), 32'd0);
    endtask

    function automatic logic [47:0] entry_addr(input int n);
        logic [47:0] a;
        for (int k = 0; k < 6; k++) a[8*(5-k) +: 8] = tbl[n][k];
        return a;
    endfunction

    initial begin
        for (int n = 0; n < 16; n++) for (int k = 0; k < 6; k++) tbl[n][k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset outputs", 32'({verdict_valid, verdict_accept, flag_filter_fail,
                                      flag_multicast, setup_done}), 32'd0);
        // unframed bytes after reset
        rx_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rx_byte = 8'(k);
            @(negedge clk);
            chk("R9 unframed bytes", 32'(verdict_valid), 32'd0);
        end
        rx_valid = 1'b0;
        send_frame("R3 zero table after reset", 48'h0, 64);
        load_setup(1'b1, 8'h10);
        for (int n = 0; n < 16; n++) send_frame("R2 R3 entry match", entry_addr(n), 100);
        send_frame("R3 non-match reject", 48'h0200_0000_0042, 100);
        send_frame("R2 padding not stored", 48'hC3C3_C3C3_C3C3, 100);
        send_frame("R4 broadcast", 48'hFFFF_FFFF_FFFF, 100);
        send_frame("R1 len 13", entry_addr(3), 13);
        send_frame("R1 len 14", entry_addr(3), 14);
        send_frame("R1 len 2048", 48'hFFFF_FFFF_FFFF, 2048);
        send_frame("R1 len 2049", 48'hFFFF_FFFF_FFFF, 2049);
        m_pr = 1;
        send_frame("R5 promiscuous", 48'h0200_0000_0042, 100);
        send_frame("R5 promisc hit no flag", entry_addr(5), 100);
        send_frame("R4 broadcast promisc no flag", 48'hFFFF_FFFF_FFFF, 100);
        m_mc = 1;
        send_frame("R6 promisc before multicast", 48'h0100_5E00_0001, 100);
        send_frame("R1 promisc short", 48'h0200_0000_0042, 10);
        m_pr = 0; m_mc = 0; m_ra = 1;
        send_frame("R5 receive all", 48'h0A0B_0C0D_0E0F, 100);
        m_ra = 0;
        send_frame("R6 multicast no pass", 48'h0100_5E00_0001, 100);
        m_mc = 1;
        send_frame("R6 multicast pass", 48'h0100_5E00_0001, 100);
        send_frame("R6 unicast no pass", 48'h0200_5E00_0001, 100);
        send_frame("R6 broadcast no flag", 48'hFFFF_FFFF_FFFF, 100);
        m_mc = 0; m_inv = 1;
        send_frame("R7 inverse hit", entry_addr(7), 100);
        send_frame("R7 inverse miss", 48'h0200_0000_0042, 100);
        send_frame("R7 inverse broadcast", 48'hFFFF_FFFF_FFFF, 100);
        m_inv = 0;
        load_setup(1'b0, 8'h12);
        send_frame("R8 reload entry", entry_addr(0), 100);
        send_frame("R8 reload entry last", entry_addr(15), 100);
        send_frame("R8 old entry gone", 48'h1012_1416_181A, 100);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule